// File: doc/BRIEF.md
# Processor Bus-Grant and Interrupt Arbiter

This block sits beside the sequencer of a small 8-bit processor core. At every machine-cycle and instruction boundary it decides among four outcomes: hand the external bus to another master, enter a non-maskable interrupt, acknowledge a maskable interrupt, or let the core keep fetching. The sequencer supplies two strobes, `mc_end` and `instr_end`, which mark these boundaries. It also supplies `halt_req`, which signals that a halt or sleep instruction has completed. The arbiter returns enable lines for the core's bus drivers, acknowledge strobes, a program-counter load with the non-maskable vector, a halt status and a fetch permission.

The block is one state machine with six states. `RUN` is normal operation. `GRANT` means the bus belongs to an external master. `NMI` is a one-cycle entry into the non-maskable handler. `IACK` is a one-cycle maskable acknowledge. `HALT` means the core is halted or asleep. `WAKE` is the delay after leaving halt.

The transitions are as follows:
- `RUN→GRANT` is taken on a bus request at a machine-cycle end.
- `RUN→NMI` and `RUN→IACK` are taken at an instruction end.
- `RUN→HALT` is taken on a halt request.
- `GRANT→RUN` is taken once the request is withdrawn.
- `NMI→RUN` and `IACK→RUN` always follow one cycle after entry.
- `HALT→WAKE` is taken when an interrupt becomes eligible.
- `WAKE→NMI`, `WAKE→IACK` and `WAKE→RUN` are taken when the wake count expires.

A small edge latch remembers falling edges on the non-maskable pin. A down-counter times the wake delay.

Top module: `cpu_irq_arb`

## Requirements
- R1: While `rst_n` is low, `bus_oe` and `data_oe` are 0. After reset the outputs are: `busack_n`=1, `halt_n`=1, `fetch_ok`=1, `nmi_ack`=0, `iack_m1_n`=1 and `iack_iorq_n`=1.
- R2: In `RUN`, a low `busreq_n` sampled with `mc_end`=1 enters `GRANT`. This takes priority over any interrupt presented at the same edge. In `GRANT`, `busack_n`=0, `bus_oe`=0, `data_oe`=0 and `fetch_ok`=0.
- R3: When `busreq_n` is sampled high in `GRANT`, `busack_n` returns to 1 on the next clock and the core resumes in `RUN`.
- R4: A high-to-low transition of `nmi_n` is latched. Holding `nmi_n` low afterwards produces no further non-maskable entries.
- R5: A latched NMI is taken at an `instr_end` in `RUN` whatever the value of `ie`. For exactly one cycle, `nmi_ack`=1, `pc_vec`=16'h0066 and `ie_clr`=1. The entry clears the latch.
- R6: A low `int_n` is acknowledged at an `instr_end` in `RUN` only when `ie`=1, no NMI is latched and no grant is taken. The acknowledge lasts one cycle, with `iack_m1_n`=0 and `iack_iorq_n`=0 together.
- R7: `halt_req` in `RUN` with no higher event enters `HALT`. In `HALT`, `halt_n`=0, `data_oe`=0 and `fetch_ok`=0 until an NMI is latched or `int_n`=0 with `ie`=1.
- R8: On leaving `HALT`, `halt_n` rises and `fetch_ok` stays 0 for exactly 16 clocks. The eligible interrupt is then acknowledged, with NMI first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busreq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt pin, falling-edge sensitive |
| int_n | input | 1 | Maskable interrupt, level, active low |
| ie | input | 1 | Maskable interrupt enable flag |
| mc_end | input | 1 | Last clock of a machine cycle |
| instr_end | input | 1 | Last clock of an instruction |
| halt_req | input | 1 | Halt or sleep instruction completed |
| busack_n | output | 1 | Bus acknowledge, active low |
| bus_oe | output | 1 | Drive enable for the address and control strobes |
| data_oe | output | 1 | Drive enable for the data bus |
| nmi_ack | output | 1 | Non-maskable entry cycle |
| pc_load | output | 1 | Load `pc_vec` into the program counter |
| pc_vec | output | 16 | Non-maskable target address |
| ie_clr | output | 1 | Clear the maskable enable |
| iack_m1_n | output | 1 | Fetch strobe of the maskable acknowledge cycle |
| iack_iorq_n | output | 1 | I/O strobe of the maskable acknowledge cycle |
| halt_n | output | 1 | Halt or sleep status, active low |
| fetch_ok | output | 1 | Opcode fetch permitted |

## Verification
The hardest situation to reach is a halt exit in which an NMI edge and an enabled maskable level are both present when the wake count runs out. A second hard case is a bus request that lands on the same edge as an instruction end with an NMI already latched. Random stimulus seldom lines these up, so directed sequences park the core in `HALT` and then drive the competing inputs on chosen edges. They also present a request, an NMI edge and a maskable level together at one boundary. Long random runs then hold `busreq_n` low for several cycles and pulse `halt_req` rarely. A cycle model in the bench is compared with every output at each cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_GRANT,
        ST_NMI,
        ST_IACK,
        ST_HALT,
        ST_WAKE
    } arb_st_t;

    localparam logic [15:0] NMI_TARGET = 16'h0066;
endpackage

// File: rtl/arb_nmi_edge.sv
module arb_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clr,
    output logic pend
);
    logic nmi_q;
    logic fall;

    assign fall = nmi_q & ~nmi_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q <= 1'b1;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            // a new edge wins over a clear in the same cycle
            if (fall)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/arb_wake_timer.sv
module arb_wake_timer #(
    parameter int LOAD_VAL = 16,
    parameter int CNT_W    = $clog2(LOAD_VAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(LOAD_VAL);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_CNT;
        else if (cnt != '0)
            cnt <= cnt - ONE_CNT;
    end

    assign last = (cnt == ONE_CNT);
endmodule

// File: rtl/cpu_irq_arb.sv
module cpu_irq_arb
    import arb_pkg::*;
#(
    parameter int WAKE_CLKS = 16,
    parameter int VEC_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busreq_n,
    input  logic             nmi_n,
    input  logic             int_n,
    input  logic             ie,
    input  logic             mc_end,
    input  logic             instr_end,
    input  logic             halt_req,
    output logic             busack_n,
    output logic             bus_oe,
    output logic             data_oe,
    output logic             nmi_ack,
    output logic             pc_load,
    output logic [VEC_W-1:0] pc_vec,
    output logic             ie_clr,
    output logic             iack_m1_n,
    output logic             iack_iorq_n,
    output logic             halt_n,
    output logic             fetch_ok
);
    localparam int CNT_W = $clog2(WAKE_CLKS + 1);

    arb_st_t          state_q, state_d;
    logic             nmi_pend;
    logic             nmi_clr;
    logic             wake_load;
    logic [CNT_W-1:0] wake_cnt;
    logic             wake_last;
    logic             int_ok;

    assign int_ok    = ie & ~int_n;
    assign nmi_clr   = (state_d == ST_NMI) & (state_q != ST_NMI);
    assign wake_load = (state_q == ST_HALT) & (state_d == ST_WAKE);

    arb_nmi_edge u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .clr   (nmi_clr),
        .pend  (nmi_pend)
    );

    arb_wake_timer #(
        .LOAD_VAL (WAKE_CLKS),
        .CNT_W    (CNT_W)
    ) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wake_load),
        .cnt   (wake_cnt),
        .last  (wake_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (mc_end && !busreq_n)
                    state_d = ST_GRANT;
                else if (instr_end && nmi_pend)
                    state_d = ST_NMI;
                else if (instr_end && int_ok)
                    state_d = ST_IACK;
                else if (halt_req)
                    state_d = ST_HALT;
            end
            ST_GRANT: begin
                if (busreq_n)
                    state_d = ST_RUN;
            end
            ST_NMI:  state_d = ST_RUN;
            ST_IACK: state_d = ST_RUN;
            ST_HALT: begin
                if (nmi_pend || int_ok)
                    state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (wake_last) begin
                    if (nmi_pend)
                        state_d = ST_NMI;
                    else if (int_ok)
                        state_d = ST_IACK;
                    else
                        state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        busack_n    = 1'b1;
        bus_oe      = rst_n;
        data_oe     = rst_n;
        nmi_ack     = 1'b0;
        pc_load     = 1'b0;
        pc_vec      = VEC_W'(NMI_TARGET);
        ie_clr      = 1'b0;
        iack_m1_n   = 1'b1;
        iack_iorq_n = 1'b1;
        halt_n      = 1'b1;
        fetch_ok    = 1'b0;
        unique case (state_q)
            ST_RUN: fetch_ok = (wake_cnt == '0);
            ST_GRANT: begin
                busack_n = 1'b0;
                bus_oe   = 1'b0;
                data_oe  = 1'b0;
            end
            ST_NMI: begin
                nmi_ack = 1'b1;
                pc_load = 1'b1;
                ie_clr  = 1'b1;
            end
            ST_IACK: begin
                iack_m1_n   = 1'b0;
                iack_iorq_n = 1'b0;
            end
            ST_HALT: begin
                halt_n  = 1'b0;
                data_oe = 1'b0;
            end
            ST_WAKE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int WAKE_CLKS = 16,
    parameter int VEC_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busreq_n,
    input logic             busack_n,
    input logic             bus_oe,
    input logic             data_oe,
    input logic             nmi_ack,
    input logic [VEC_W-1:0] pc_vec,
    input logic             ie_clr,
    input logic             iack_m1_n,
    input logic             iack_iorq_n,
    input logic             halt_n,
    input logic             fetch_ok
);
    localparam int GAP_W = $clog2(WAKE_CLKS + 1);

    logic             halt_prev;
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_prev <= 1'b1;
            gap       <= '0;
        end else begin
            halt_prev <= halt_n;
            if (halt_n && !halt_prev)
                gap <= GAP_W'(WAKE_CLKS - 1);
            else if (gap != '0)
                gap <= gap - GAP_W'(1);
        end
    end

    // R2
    grant_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busack_n |-> (!bus_oe && !data_oe && !fetch_ok));

    // R3
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busack_n && busreq_n) |=> busack_n);

    // R5
    nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |-> (pc_vec == 16'h0066 && ie_clr));

    // R5
    nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |=> !nmi_ack);

    // R6
    iack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_m1_n |-> (!iack_iorq_n && iack_m1_n == iack_iorq_n));

    // R6
    iack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_m1_n |=> iack_m1_n);

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |-> (!data_oe && !fetch_ok));

    // R8
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_n) |-> !fetch_ok);

    // R8
    wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap != '0) |-> !fetch_ok);
endmodule

bind cpu_irq_arb arb_chk #(
    .WAKE_CLKS (WAKE_CLKS),
    .VEC_W     (VEC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busreq_n    (busreq_n),
    .busack_n    (busack_n),
    .bus_oe      (bus_oe),
    .data_oe     (data_oe),
    .nmi_ack     (nmi_ack),
    .pc_vec      (pc_vec),
    .ie_clr      (ie_clr),
    .iack_m1_n   (iack_m1_n),
    .iack_iorq_n (iack_iorq_n),
    .halt_n      (halt_n),
    .fetch_ok    (fetch_ok)
);

// File: tb/cpu_irq_arb_bench.sv
`timescale 1ns/1ps
module cpu_irq_arb_bench;
    localparam int M_RUN = 0, M_GRANT = 1, M_NMI = 2, M_IACK = 3, M_HALT = 4, M_WAKE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busreq_n = 1'b1, nmi_n = 1'b1, int_n = 1'b1, ie = 1'b0;
    logic        mc_end = 1'b0, instr_end = 1'b0, halt_req = 1'b0;
    logic        busack_n, bus_oe, data_oe, nmi_ack, pc_load, ie_clr;
    logic        iack_m1_n, iack_iorq_n, halt_n, fetch_ok;
    logic [15:0] pc_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cpu_irq_arb u_cpu_irq_arb (
        .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .nmi_n(nmi_n), .int_n(int_n),
        .ie(ie), .mc_end(mc_end), .instr_end(instr_end), .halt_req(halt_req),
        .busack_n(busack_n), .bus_oe(bus_oe), .data_oe(data_oe), .nmi_ack(nmi_ack),
        .pc_load(pc_load), .pc_vec(pc_vec), .ie_clr(ie_clr), .iack_m1_n(iack_m1_n),
        .iack_iorq_n(iack_iorq_n), .halt_n(halt_n), .fetch_ok(fetch_ok)
    );

    // cycle model built from the requirements
    int       m_st;
    logic     m_pend, m_nq;
    int       m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= M_RUN; m_pend <= 1'b0; m_nq <= 1'b1; m_cnt <= 0;
        end else begin
            int  nx;
            logic fall, iok;
            fall = m_nq && !nmi_n;
            iok  = ie && !int_n;
            nx   = m_st;
            case (m_st)
                M_RUN:   if (mc_end && !busreq_n) nx = M_GRANT;
                         else if (instr_end && m_pend) nx = M_NMI;
                         else if (instr_end && iok) nx = M_IACK;
                         else if (halt_req) nx = M_HALT;
                M_GRANT: if (busreq_n) nx = M_RUN;
                M_NMI, M_IACK: nx = M_RUN;
                M_HALT:  if (m_pend || iok) nx = M_WAKE;
                default: if (m_cnt == 1) nx = m_pend ? M_NMI : (iok ? M_IACK : M_RUN);
            endcase
            m_pend <= fall ? 1'b1 : ((nx == M_NMI && m_st != M_NMI) ? 1'b0 : m_pend);
            m_nq   <= nmi_n;
            m_cnt  <= (m_st == M_HALT && nx == M_WAKE) ? 16 : ((m_cnt != 0) ? m_cnt - 1 : 0);
            m_st   <= nx;
        end
    end

    function automatic string tag_of(int st);
        case (st)
            M_GRANT: return "R2";
            M_NMI:   return "R5";
            M_IACK:  return "R6";
            M_HALT:  return "R7";
            M_WAKE:  return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        string t;
        t = tag_of(m_st);
        chk(t, {31'd0, busack_n},    {31'd0, m_st != M_GRANT});
        chk(t, {31'd0, bus_oe},      {31'd0, m_st != M_GRANT});
        chk(t, {31'd0, data_oe},     {31'd0, m_st != M_GRANT && m_st != M_HALT});
        chk(t, {31'd0, nmi_ack},     {31'd0, m_st == M_NMI});
        chk(t, {31'd0, iack_m1_n},   {31'd0, m_st != M_IACK});
        chk(t, {31'd0, iack_iorq_n}, {31'd0, m_st != M_IACK});
        chk(t, {31'd0, halt_n},      {31'd0, m_st != M_HALT});
        chk(t, {31'd0, fetch_ok},    {31'd0, m_st == M_RUN && m_cnt == 0});
        if (m_st == M_NMI) chk("R5", {16'd0, pc_vec}, 32'h0066);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic idle_inputs();
        busreq_n = 1'b1; int_n = 1'b1; mc_end = 1'b0; instr_end = 1'b0; halt_req = 1'b0;
    endtask

    initial begin
        int n;
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, bus_oe}, 32'd0);
        chk("R1", {31'd0, data_oe}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1", {31'd0, busack_n}, 32'd1);
        chk("R1", {31'd0, halt_n}, 32'd1);
        chk("R1", {31'd0, fetch_ok}, 32'd1);
        chk("R1", {31'd0, iack_m1_n}, 32'd1);

        // R4/R5: NMI with interrupts disabled
        ie = 1'b0; nmi_n = 1'b0; tick(); tick();
        instr_end = 1'b1; tick();
        chk("R5", {31'd0, nmi_ack}, 32'd1);
        chk("R5", {16'd0, pc_vec}, 32'h0066);
        chk("R5", {31'd0, ie_clr}, 32'd1);
        n = 0;
        for (int i = 0; i < 6; i++) begin tick(); n += nmi_ack; end
        chk("R4", n, 0);
        instr_end = 1'b0; nmi_n = 1'b1; tick();

        // R6: maskable ignored while disabled
        int_n = 1'b0; ie = 1'b0; instr_end = 1'b1;
        n = 0;
        for (int i = 0; i < 5; i++) begin tick(); n += !iack_m1_n; end
        chk("R6", n, 0);
        ie = 1'b1; tick();
        chk("R6", {30'd0, iack_m1_n, iack_iorq_n}, 32'd0);
        idle_inputs(); tick();

        // R2: request beats a latched NMI and an enabled level at the same edge
        nmi_n = 1'b0; tick();
        busreq_n = 1'b0; mc_end = 1'b1; instr_end = 1'b1; int_n = 1'b0; tick();
        chk("R2", {31'd0, busack_n}, 32'd0);
        chk("R2", {31'd0, nmi_ack}, 32'd0);
        tick(); tick();
        busreq_n = 1'b1; tick();
        chk("R3", {31'd0, busack_n}, 32'd1);
        tick();
        chk("R5", {31'd0, nmi_ack}, 32'd1);
        idle_inputs(); nmi_n = 1'b1; tick();

        // R7/R8: halt, then wake with NMI and maskable both eligible
        halt_req = 1'b1; tick(); halt_req = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        chk("R7", {31'd0, halt_n}, 32'd0);
        chk("R7", {31'd0, data_oe}, 32'd0);
        ie = 1'b1; int_n = 1'b0; nmi_n = 1'b0; tick();
        n = 0;
        while (halt_n && !fetch_ok && !nmi_ack && iack_m1_n && n < 40) begin n++; tick(); end
        chk("R8", n, 16);
        chk("R8", {31'd0, nmi_ack}, 32'd1);
        tick();
        chk("R8", {31'd0, iack_m1_n}, 32'd1);
        idle_inputs(); nmi_n = 1'b1; tick();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (!busack_n) busreq_n = ($urandom % 100) < 70 ? 1'b0 : 1'b1;
            else           busreq_n = ($urandom % 100) < 12 ? 1'b0 : 1'b1;
            if (($urandom % 100) < 6) nmi_n = ~nmi_n;
            int_n     = ($urandom % 100) < 20 ? 1'b0 : 1'b1;
            ie        = ($urandom % 100) < 70;
            mc_end    = ($urandom % 100) < 40;
            instr_end = ($urandom % 100) < 25;
            halt_req  = ($urandom % 100) < 4;
            tick();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule